// File: doc/BRIEF.md
# Transmit Byte FIFO with Free-Space Threshold

This block is a byte-wide queue. It sits between a host write path and a packet transmitter. The host pushes one byte per cycle, and each byte carries an end-of-packet tag. The transmitter pops entries in order and gets each one back through a registered read port. The storage is a simple dual-port array that can map to block RAM.

A 5-bit level register sets a free-space threshold of `level*8+1` bytes. The live "room" flag is high while the number of empty entries is at least that threshold. The flag is offered three ways:

- the live bit;
- a latched bit, set when the live bit rises and cleared by writing a one;
- an interrupt, which is the latched bit gated by an enable.

Two more controls complete the block. A one-cycle flush pulse empties the queue. A push into a full queue is dropped and sets a sticky overflow bit, which is also cleared by writing a one.

Top module: `hdlc_txfifo_room`

## Requirements
- R1: After reset the free count is 256, the live room flag is 1, the latched flag, the interrupt and the overflow bit are 0, and the level reads 8.
- R2: Popped entries come out in push order with their end-of-packet tag; `pop_vld` is high, with data, in the cycle after an accepted pop and low otherwise.
- R3: The live room flag equals (free count >= level*8+1), and it changes at the same clock edge as the push, pop, flush or level write that causes the change.
- R4: With level 21 the live flag is 1 at 169 free bytes and 0 at 168 free bytes.
- R5: With the reset level of 8 the live flag is 1 at 65 free bytes and 0 at 64 free bytes.
- R6: The latched flag becomes 1 at the edge where the live flag goes from 0 to 1. It stays 1 after the live flag falls. A write with `w1c_data[0]=1` clears it, but a rising edge in the same cycle wins over the clear.
- R7: `irq` is 1 exactly when the latched flag and the interrupt enable are both 1.
- R8: A push while the free count is 0 is dropped: the count stays 0 and stored data is unchanged. It also sets the overflow bit, which stays set until a write with `w1c_data[1]=1`.
- R9: A `flush` pulse makes the free count 256 at the next edge. A push in the same cycle is ignored and does not set overflow.
- R10: A pop while the queue is empty leaves the free count unchanged and gives no `pop_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push one entry |
| push_byte | input | 8 | Byte to push |
| push_eop | input | 1 | End-of-packet tag of pushed byte |
| pop_en | input | 1 | Pop one entry |
| pop_byte | output | 8 | Popped byte (registered) |
| pop_eop | output | 1 | End-of-packet tag of popped byte |
| pop_vld | output | 1 | Popped entry valid this cycle |
| flush | input | 1 | One-cycle queue reset pulse |
| lvl_we | input | 1 | Write the level register |
| lvl_wdata | input | 5 | New level value |
| lvl_q | output | 5 | Current level |
| ien_we | input | 1 | Write the interrupt enable |
| ien_wdata | input | 1 | New interrupt enable value |
| w1c_we | input | 1 | Write-one-to-clear strobe |
| w1c_data | input | 2 | Bit 0 clears the latched room flag, bit 1 clears overflow |
| free_cnt | output | 9 | Number of empty entries |
| room_live | output | 1 | Live room flag |
| room_latched | output | 1 | Latched room flag |
| ovf_sticky | output | 1 | Sticky overflow bit |
| irq | output | 1 | Latched flag AND enable |

## Verification
Every register update is due at the first clock edge after the input that causes it:

- the free count, the live flag and the latched flag;
- the overflow bit and the interrupt;
- `pop_vld` and `pop_byte` for an accepted pop.

So none of these is combinational through the same cycle. The bench changes inputs just after a falling edge and holds them through exactly one rising edge. It then reads the outputs at the next falling edge, which is the single cycle in which each result is due. The threshold edges (168/169 at level 21, 64/65 at level 8), the set-versus-clear collision and the full/empty boundaries are each reached by counting pushes and pops, so the expected free count is known in the bench at every step.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              eop;
    logic [BYTE_W-1:0] data;
  } txf_ent_t;

  localparam int ENT_W = $bits(txf_ent_t);
endpackage

// File: rtl/txf_store.sv
module txf_store
  import txf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  txf_ent_t      wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output txf_ent_t      rdata,
  output logic          rvld
);
  localparam int DEPTH = 1 << AW;

  txf_ent_t mem [DEPTH];

  // Storage array: no reset, so it can map to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvld <= 1'b0;
    else     rvld <= re;
  end
endmodule

// File: rtl/txf_ptrs.sv
module txf_ptrs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic          ovf_clr,
  output logic          do_wr,
  output logic          do_rd,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW:0]   cnt_q,
  output logic [AW:0]   cnt_nxt,
  output logic          ovf
);
  localparam int          CW    = AW + 1;
  localparam logic [CW-1:0] DEPTH = CW'(1 << AW);

  logic full, empty;

  assign full  = (cnt_q == DEPTH);
  assign empty = (cnt_q == '0);
  assign do_wr = push & ~full  & ~flush;
  assign do_rd = pop  & ~empty & ~flush;

  always_comb begin
    if (flush) begin
      cnt_nxt = '0;
    end else begin
      unique case ({do_wr, do_rd})
        2'b10:   cnt_nxt = cnt_q + CW'(1);
        2'b01:   cnt_nxt = cnt_q - CW'(1);
        default: cnt_nxt = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_wr) wptr <= wptr + AW'(1);
      if (do_rd) rptr <= rptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // Sticky overflow: setting wins over clearing.
  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else     ovf <= (push & full & ~flush) | (ovf & ~ovf_clr);
  end
endmodule

// File: rtl/txf_room_stat.sv
module txf_room_stat #(
  parameter int              AW        = 8,
  parameter int              LVL_W     = 5,
  parameter logic [LVL_W-1:0] LVL_RESET = LVL_W'(8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW:0]      cnt_nxt,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  input  logic             ien_we,
  input  logic             ien_wdata,
  input  logic             lat_clr,
  output logic [LVL_W-1:0] lvl_q,
  output logic             ien_q,
  output logic             live_q,
  output logic             lat_q,
  output logic             irq_q
);
  localparam int CW = AW + 1;
  localparam int TW = LVL_W + 4;
  localparam int MW = (CW > TW) ? CW : TW;
  localparam logic [CW-1:0] DEPTH = CW'(1 << AW);

  logic [LVL_W-1:0] lvl_nxt;
  logic             ien_nxt;
  logic [CW-1:0]    free_nxt;
  logic [TW-1:0]    thr;
  logic             live_nxt;
  logic             lat_nxt;

  assign lvl_nxt  = lvl_we ? lvl_wdata : lvl_q;
  assign ien_nxt  = ien_we ? ien_wdata : ien_q;
  assign free_nxt = DEPTH - cnt_nxt;
  assign thr      = {1'b0, lvl_nxt, 3'b000} + TW'(1);
  assign live_nxt = MW'(free_nxt) >= MW'(thr);
  // A rising edge of the live flag takes priority over a clear.
  assign lat_nxt  = (live_nxt & ~live_q) | (lat_q & ~lat_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_RESET;
      ien_q  <= 1'b0;
      live_q <= 1'b1;  // an empty queue always meets the largest threshold
      lat_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_nxt;
      ien_q  <= ien_nxt;
      live_q <= live_nxt;
      lat_q  <= lat_nxt;
      irq_q  <= lat_nxt & ien_nxt;
    end
  end
endmodule

// File: rtl/hdlc_txfifo_room.sv
module hdlc_txfifo_room
  import txf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       push_en,
  input  logic [7:0] push_byte,
  input  logic       push_eop,
  input  logic       pop_en,
  output logic [7:0] pop_byte,
  output logic       pop_eop,
  output logic       pop_vld,
  input  logic       flush,
  input  logic       lvl_we,
  input  logic [4:0] lvl_wdata,
  output logic [4:0] lvl_q,
  input  logic       ien_we,
  input  logic       ien_wdata,
  input  logic       w1c_we,
  input  logic [1:0] w1c_data,
  output logic [8:0] free_cnt,
  output logic       room_live,
  output logic       room_latched,
  output logic       ovf_sticky,
  output logic       irq
);
  localparam int AW    = 8;
  localparam int LVL_W = 5;
  localparam int CW    = AW + 1;
  localparam logic [CW-1:0] DEPTH = CW'(1 << AW);

  logic          do_wr, do_rd;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ien_q;
  txf_ent_t      wr_ent, rd_ent;

  assign wr_ent = '{eop: push_eop, data: push_byte};

  txf_ptrs #(.AW(AW)) ptrs_i (
    .clk     (clk),
    .rst     (rst),
    .push    (push_en),
    .pop     (pop_en),
    .flush   (flush),
    .ovf_clr (w1c_we & w1c_data[1]),
    .do_wr   (do_wr),
    .do_rd   (do_rd),
    .wptr    (wptr),
    .rptr    (rptr),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .ovf     (ovf_sticky)
  );

  txf_store #(.AW(AW)) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (do_wr),
    .waddr (wptr),
    .wdata (wr_ent),
    .re    (do_rd),
    .raddr (rptr),
    .rdata (rd_ent),
    .rvld  (pop_vld)
  );

  txf_room_stat #(.AW(AW), .LVL_W(LVL_W), .LVL_RESET(5'd8)) room_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_nxt   (cnt_nxt),
    .lvl_we    (lvl_we),
    .lvl_wdata (lvl_wdata),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .lat_clr   (w1c_we & w1c_data[0]),
    .lvl_q     (lvl_q),
    .ien_q     (ien_q),
    .live_q    (room_live),
    .lat_q     (room_latched),
    .irq_q     (irq)
  );

  assign pop_byte = rd_ent.data;
  assign pop_eop  = rd_ent.eop;
  assign free_cnt = DEPTH - cnt_q;
endmodule

// File: rtl/txf_checker.sv
module txf_checker (
  input logic       clk,
  input logic       rst,
  input logic       push_en,
  input logic       pop_en,
  input logic       pop_vld,
  input logic       flush,
  input logic [4:0] lvl_q,
  input logic       ien_q,
  input logic [8:0] free_cnt,
  input logic       room_live,
  input logic       room_latched,
  input logic       ovf_sticky,
  input logic       irq
);
  AST_LIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
    room_live == (int'(free_cnt) >= int'(lvl_q) * 8 + 1)); // R3

  AST_LATCH_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(room_live) |-> room_latched); // R6

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq == (room_latched && ien_q)); // R7

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push_en && free_cnt == 9'd0 && !pop_en && !flush) |=> (free_cnt == 9'd0 && ovf_sticky)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (free_cnt == 9'd256)); // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop_en && free_cnt == 9'd256 && !push_en) |=> (!pop_vld && free_cnt == 9'd256)); // R10

  AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
    pop_vld |-> $past(pop_en)); // R2
endmodule

bind hdlc_txfifo_room txf_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .push_en      (push_en),
  .pop_en       (pop_en),
  .pop_vld      (pop_vld),
  .flush        (flush),
  .lvl_q        (lvl_q),
  .ien_q        (ien_q),
  .free_cnt     (free_cnt),
  .room_live    (room_live),
  .room_latched (room_latched),
  .ovf_sticky   (ovf_sticky),
  .irq          (irq)
);

// File: tb/hdlc_txfifo_room_tb_top.sv
module hdlc_txfifo_room_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_en = 1'b0;
  logic [7:0] push_byte = '0;
  logic       push_eop = 1'b0;
  logic       pop_en = 1'b0;
  logic [7:0] pop_byte;
  logic       pop_eop;
  logic       pop_vld;
  logic       flush = 1'b0;
  logic       lvl_we = 1'b0;
  logic [4:0] lvl_wdata = '0;
  logic [4:0] lvl_q;
  logic       ien_we = 1'b0;
  logic       ien_wdata = 1'b0;
  logic       w1c_we = 1'b0;
  logic [1:0] w1c_data = '0;
  logic [8:0] free_cnt;
  logic       room_live;
  logic       room_latched;
  logic       ovf_sticky;
  logic       irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  hdlc_txfifo_room dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every task starts just after a falling edge and returns at one.
  task automatic push_one(input logic [7:0] b, input logic e);
    push_en = 1'b1; push_byte = b; push_eop = e;
    @(negedge clk);
    push_en = 1'b0; push_eop = 1'b0;
  endtask

  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) push_one(8'((base + i) ^ 8'h5A), 1'b0);
  endtask

  task automatic pop_one();
    pop_en = 1'b1;
    @(negedge clk);
    pop_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic set_level(input logic [4:0] v);
    lvl_we = 1'b1; lvl_wdata = v;
    @(negedge clk);
    lvl_we = 1'b0;
  endtask

  task automatic w1c(input logic [1:0] m);
    w1c_we = 1'b1; w1c_data = m;
    @(negedge clk);
    w1c_we = 1'b0; w1c_data = '0;
  endtask

  task automatic t_reset();
    check("R1 free", free_cnt, 256);
    check("R1 live", room_live, 1);
    check("R1 latched", room_latched, 0);
    check("R1 irq", irq, 0);
    check("R1 ovf", ovf_sticky, 0);
    check("R1 level", lvl_q, 8);
  endtask

  task automatic t_order();
    push_one(8'h11, 1'b0);
    push_one(8'hA2, 1'b0);
    push_one(8'h3C, 1'b1);
    check("R3 free after 3 pushes", free_cnt, 253);
    check("R2 no vld without pop", pop_vld, 0);
    pop_one();
    check("R2 vld", pop_vld, 1);
    check("R2 byte0", pop_byte, 8'h11);
    check("R2 eop0", pop_eop, 0);
    pop_one();
    check("R2 byte1", pop_byte, 8'hA2);
    pop_one();
    check("R2 byte2", pop_byte, 8'h3C);
    check("R2 eop2", pop_eop, 1);
    @(negedge clk);
    check("R2 vld drops", pop_vld, 0);
    check("R3 free back", free_cnt, 256);
  endtask

  task automatic t_level21();
    do_flush();
    set_level(5'd21);
    check("R3 level", lvl_q, 21);
    push_n(87, 0);
    check("R4 free 169", free_cnt, 169);
    check("R4 live at 169", room_live, 1);
    push_one(8'h00, 1'b0);
    check("R4 live at 168", room_live, 0);
    check("R6 no latch on fall", room_latched, 0);
    // Rising edge and clear in the same cycle: the set wins.
    pop_en = 1'b1; w1c_we = 1'b1; w1c_data = 2'b01;
    @(negedge clk);
    pop_en = 1'b0; w1c_we = 1'b0; w1c_data = '0;
    check("R4 live back at 169", room_live, 1);
    check("R6 set beats clear", room_latched, 1);
    check("R7 irq masked", irq, 0);
    ien_we = 1'b1; ien_wdata = 1'b1;
    @(negedge clk);
    ien_we = 1'b0;
    check("R7 irq enabled", irq, 1);
    w1c(2'b01);
    check("R6 cleared", room_latched, 0);
    check("R7 irq after clear", irq, 0);
    ien_we = 1'b1; ien_wdata = 1'b0;
    @(negedge clk);
    ien_we = 1'b0;
  endtask

  task automatic t_level8();
    do_flush();
    set_level(5'd8);
    push_n(191, 0);
    check("R5 live at 65", room_live, 1);
    push_one(8'h00, 1'b0);
    check("R5 live at 64", room_live, 0);
    pop_one();
    check("R5 live at 65 again", room_live, 1);
    check("R6 latched on rise", room_latched, 1);
    push_one(8'h00, 1'b0);
    check("R6 held after fall", room_latched, 1);
    w1c(2'b01);
    check("R6 w1c", room_latched, 0);
  endtask

  task automatic t_overflow();
    do_flush();
    push_n(256, 0);
    check("R8 full", free_cnt, 0);
    check("R8 no ovf yet", ovf_sticky, 0);
    push_one(8'hEE, 1'b1);
    check("R8 still full", free_cnt, 0);
    check("R8 ovf set", ovf_sticky, 1);
    pop_one();
    check("R8 first byte", pop_byte, 8'h5A);
    for (int i = 1; i < 256; i++) pop_one();
    check("R8 last byte kept", pop_byte, 8'hFF ^ 8'h5A);
    check("R8 last eop", pop_eop, 0);
    check("R8 drained", free_cnt, 256);
    check("R8 ovf sticky", ovf_sticky, 1);
    w1c(2'b10);
    check("R8 ovf cleared", ovf_sticky, 0);
  endtask

  task automatic t_flush();
    push_n(3, 0);
    push_en = 1'b1; push_byte = 8'h77; flush = 1'b1;
    @(negedge clk);
    push_en = 1'b0; flush = 1'b0;
    check("R9 flushed", free_cnt, 256);
    check("R9 no ovf", ovf_sticky, 0);
  endtask

  task automatic t_empty_pop();
    pop_one();
    check("R10 no vld", pop_vld, 0);
    check("R10 free", free_cnt, 256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_level21();
    t_level8();
    t_overflow();
    t_flush();
    t_empty_pop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule